// File: doc/BRIEF.md
# Multi-Bus Interrupt Status Aggregator

This block keeps, for every bus of a multi-bus two-wire serial controller, an interrupt enable register and an interrupt status register, and folds them into one interrupt line per bus plus a controller-wide pending map with one bit per bus. The transfer engine of each bus reports completed events as single-cycle pulses: address or data acknowledged, not acknowledged, byte received, arbitration lost, clean stop, stop issued with no transfer active, and clock-low timeout. Each pulse is an interrupt raise. A raise first merges the new events into the status register and then masks the whole register with the enable register. If anything survives, the bus's line and its pending-map bit are set.

Software writes through one register write port that selects a bus and a register. Writing the status register clears every bit written as one. When the write leaves the status register empty, the line and the pending-map bit drop. If the write clears a byte-received flag while the engine still holds a receive command, the block issues a one-cycle re-arm request so that the engine starts the next byte. A registered read port returns the enable register, the status register or the pending map.

Top module: `irq_status_agg`

## Requirements
- R1: While `rst` is high, all enable registers, status registers, lines, pending-map bits and re-arm outputs are cleared. Reads return zero from the cycle after the reset is released.
- R2: A write with `wr_sel`=0 loads the selected bus's enable register with `wr_data[14:0]`. Higher data bits are dropped. A read with `rd_sel`=0 returns the register zero-extended, one cycle after the read request.
- R3: Event inputs map to status bits: tx ack = bit 0, tx nak = bit 1, rx done = bit 2, arbitration loss = bit 3, normal stop = bit 4, abnormal stop = bit 5, clock timeout = bit 6. When any event pulses on a bus, that bus's status becomes (status OR events) AND enable at the next edge. An event on a disabled bit therefore leaves no trace.
- R4: When a raise leaves a nonzero status, that bus's `irq` bit and pending-map bit (read with `rd_sel`=2, bit n = bus n) go high at the same edge as the status update.
- R5: A write with `wr_sel`=1 clears exactly those status bits of the selected bus whose data bit is one. Status bits written as zero are kept.
- R6: Any status write that leaves the status register zero lowers that bus's `irq` and pending-map bit at the same edge. A write that leaves some bit set keeps them high.
- R7: `rx_rearm[n]` pulses for one cycle, registered, when a status write to bus n clears bit 2 while bit 2 was set and `rx_pending[n]` is high. The pulse does not occur when bit 2 was already clear or when `rx_pending[n]` is low.
- R8: `bus_rst[n]` clears bus n's enable register, status register, `irq` bit and pending-map bit, and leaves the other buses unchanged.
- R9: Writes with `wr_sel`=2 (pending map) or 3 change nothing.
- R10: Lowering enable bits does not prune status bits already stored and does not drop a raised line. Only a later raise applies the mask. A raise whose masked result is zero keeps a line that is already high.
- R11: When a status write and events reach the same bus in one cycle, the clear is applied first and the events second, so the new event bits survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| bus_rst | input | NUM_BUS | Per-bus synchronous reset of enable, status and line |
| wr_en | input | 1 | Register write strobe |
| wr_bus | input | IDX_W | Bus selected by the write |
| wr_sel | input | 2 | Register selected: 0 enable, 1 status, 2 pending map, 3 none |
| wr_data | input | DATA_W | Write data |
| rd_bus | input | IDX_W | Bus selected by the read |
| rd_sel | input | 2 | Register read, same encoding as `wr_sel` |
| rd_data | output | DATA_W | Registered read data, valid one cycle after the request |
| ev_tx_ack | input | NUM_BUS | Acknowledge seen, per bus |
| ev_tx_nak | input | NUM_BUS | No acknowledge, per bus |
| ev_rx_done | input | NUM_BUS | Byte received, per bus |
| ev_arb_loss | input | NUM_BUS | Arbitration lost, per bus |
| ev_stop_ok | input | NUM_BUS | Clean stop completed, per bus |
| ev_stop_bad | input | NUM_BUS | Stop requested with no transfer active, per bus |
| ev_scl_timeout | input | NUM_BUS | Clock held low too long, per bus |
| rx_pending | input | NUM_BUS | Engine still holds a receive command, per bus |
| irq | output | NUM_BUS | Registered interrupt line per bus |
| rx_rearm | output | NUM_BUS | One-cycle request to start the next receive |

## Verification
The bench first drives events into bits that are enabled and into bits that are not. This separates correct masking from a design that stores raw events. Partial and complete clears show whether the line follows an empty status register or only the write itself. Lowering the enable register after a raise, and then pulsing a masked-out event, shows that pruning happens only on a raise and never removes a line already high. The re-arm output is tried with rx done set and a receive pending, with rx done already clear, and with no receive pending. Writes that coincide with events test clear-before-set ordering. Resets of one bus and of the whole controller check that only the intended state goes away.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  // Width of the per-bus enable and status registers.
  localparam int STAT_W = 15;

  // Status bit positions driven by engine events.
  localparam int EV_TX_ACK    = 0;
  localparam int EV_TX_NAK    = 1;
  localparam int EV_RX_DONE   = 2;
  localparam int EV_ARB_LOSS  = 3;
  localparam int EV_STOP_OK   = 4;
  localparam int EV_STOP_BAD  = 5;
  localparam int EV_SCL_TMO   = 6;

  // Register selector shared by the write and read ports.
  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_STATUS  = 2'd1,
    SEL_PENDMAP = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_bus_slice.sv
// One bus worth of enable, status, line and receive re-arm state.
module irq_bus_slice #(
  parameter int STAT_W  = 15,
  parameter int RX_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              en_wr,
  input  logic              st_wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] ev,
  input  logic              rx_pending,
  output logic [STAT_W-1:0] en_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              line_q,
  output logic              rearm_q
);

  logic [STAT_W-1:0] cleared;
  logic [STAT_W-1:0] merged;
  logic              raise;
  logic              line_d;
  logic              rearm_d;

  always_comb begin
    // Clear first, then merge and mask on a raise.
    cleared = st_wr ? (stat_q & ~wdata) : stat_q;
    raise   = |ev;
    merged  = raise ? ((cleared | ev) & en_q) : cleared;

    line_d = line_q;
    if (st_wr && (cleared == '0)) line_d = 1'b0;
    if (raise && (merged != '0))  line_d = 1'b1;

    rearm_d = st_wr && stat_q[RX_BIT] && wdata[RX_BIT] && rx_pending;
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      en_q    <= '0;
      stat_q  <= '0;
      line_q  <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= wdata;
      stat_q  <= merged;
      line_q  <= line_d;
      rearm_q <= rearm_d;
    end
  end

endmodule

// File: rtl/irq_read_port.sv
// Registered read mux over all buses and the pending map.
module irq_read_port
  import i2c_irq_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [IDX_W-1:0]               rd_bus,
  input  logic [1:0]                     rd_sel,
  input  logic [NUM_BUS-1:0][STAT_W-1:0] en_all,
  input  logic [NUM_BUS-1:0][STAT_W-1:0] stat_all,
  input  logic [NUM_BUS-1:0]             pend,
  output logic [DATA_W-1:0]              rd_data
);

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (rd_sel)
      SEL_ENABLE:  if (int'(rd_bus) < NUM_BUS) rd_d[STAT_W-1:0] = en_all[rd_bus];
      SEL_STATUS:  if (int'(rd_bus) < NUM_BUS) rd_d[STAT_W-1:0] = stat_all[rd_bus];
      SEL_PENDMAP: rd_d[NUM_BUS-1:0] = pend;
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import i2c_irq_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUS-1:0] bus_rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_bus,
  input  logic [1:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd_bus,
  input  logic [1:0]         rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_BUS-1:0] ev_tx_ack,
  input  logic [NUM_BUS-1:0] ev_tx_nak,
  input  logic [NUM_BUS-1:0] ev_rx_done,
  input  logic [NUM_BUS-1:0] ev_arb_loss,
  input  logic [NUM_BUS-1:0] ev_stop_ok,
  input  logic [NUM_BUS-1:0] ev_stop_bad,
  input  logic [NUM_BUS-1:0] ev_scl_timeout,
  input  logic [NUM_BUS-1:0] rx_pending,
  output logic [NUM_BUS-1:0] irq,
  output logic [NUM_BUS-1:0] rx_rearm
);

  logic [NUM_BUS-1:0][STAT_W-1:0] en_all;
  logic [NUM_BUS-1:0][STAT_W-1:0] stat_all;
  logic [NUM_BUS-1:0]             line_vec;
  logic [NUM_BUS-1:0]             ev_hit;
  logic                           unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:STAT_W];

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
    logic [STAT_W-1:0] ev_vec;
    logic              bus_hit;
    logic              en_wr;
    logic              st_wr;

    always_comb begin
      ev_vec              = '0;
      ev_vec[EV_TX_ACK]   = ev_tx_ack[g];
      ev_vec[EV_TX_NAK]   = ev_tx_nak[g];
      ev_vec[EV_RX_DONE]  = ev_rx_done[g];
      ev_vec[EV_ARB_LOSS] = ev_arb_loss[g];
      ev_vec[EV_STOP_OK]  = ev_stop_ok[g];
      ev_vec[EV_STOP_BAD] = ev_stop_bad[g];
      ev_vec[EV_SCL_TMO]  = ev_scl_timeout[g];
    end

    assign bus_hit   = wr_en && (int'(wr_bus) == g);
    assign en_wr     = bus_hit && (wr_sel == SEL_ENABLE);
    assign st_wr     = bus_hit && (wr_sel == SEL_STATUS);
    assign ev_hit[g] = |ev_vec;

    irq_bus_slice #(
      .STAT_W (STAT_W),
      .RX_BIT (EV_RX_DONE)
    ) u_slice (
      .clk        (clk),
      .rst        (rst),
      .bus_rst    (bus_rst[g]),
      .en_wr      (en_wr),
      .st_wr      (st_wr),
      .wdata      (wr_data[STAT_W-1:0]),
      .ev         (ev_vec),
      .rx_pending (rx_pending[g]),
      .en_q       (en_all[g]),
      .stat_q     (stat_all[g]),
      .line_q     (line_vec[g]),
      .rearm_q    (rx_rearm[g])
    );
  end

  // The line flops double as the controller-wide pending map.
  assign irq = line_vec;

  irq_read_port #(
    .NUM_BUS (NUM_BUS),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_bus   (rd_bus),
    .rd_sel   (rd_sel),
    .en_all   (en_all),
    .stat_all (stat_all),
    .pend     (line_vec),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
  import i2c_irq_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_BUS-1:0]             bus_rst,
  input logic                           wr_en,
  input logic [IDX_W-1:0]               wr_bus,
  input logic [1:0]                     wr_sel,
  input logic [DATA_W-1:0]              wr_data,
  input logic [NUM_BUS-1:0]             rx_pending,
  input logic [NUM_BUS-1:0]             ev_hit,
  input logic [NUM_BUS-1:0][STAT_W-1:0] en_all,
  input logic [NUM_BUS-1:0]             irq,
  input logic [NUM_BUS-1:0]             rx_rearm
);

  // R1: reset empties lines and re-arm requests.
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (irq == '0 && rx_rearm == '0));

  // R9: pending-map writes alone leave every line untouched.
  assert_map_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_PENDMAP && ev_hit == '0 && bus_rst == '0) |=> $stable(irq));

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_chk
    // R2: enable register takes the low data bits.
    assert_enable_load_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && int'(wr_bus) == b && wr_sel == SEL_ENABLE && !bus_rst[b])
      |=> en_all[b] == $past(wr_data[STAT_W-1:0]));

    // R4: a line only rises after an event on that bus.
    assert_irq_rise_cause_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[b]) |-> $past(ev_hit[b]));

    // R6: a line only falls after a status write or a reset.
    assert_irq_fall_cause_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(irq[b]) |-> $past(rst || bus_rst[b] ||
                              (wr_en && int'(wr_bus) == b && wr_sel == SEL_STATUS)));

    // R7: a re-arm request needs a clearing write with a receive pending.
    assert_rearm_cause_R7: assert property (@(posedge clk) disable iff (rst)
      rx_rearm[b] |-> $past(wr_en && int'(wr_bus) == b && wr_sel == SEL_STATUS &&
                            wr_data[EV_RX_DONE] && rx_pending[b]));
  end

endmodule

bind irq_status_agg irq_status_agg_chk #(
  .NUM_BUS (NUM_BUS),
  .DATA_W  (DATA_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rst    (bus_rst),
  .wr_en      (wr_en),
  .wr_bus     (wr_bus),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .rx_pending (rx_pending),
  .ev_hit     (ev_hit),
  .en_all     (en_all),
  .irq        (irq),
  .rx_rearm   (rx_rearm)
);

// File: tb/irq_status_agg_tb.sv
`timescale 1ns/1ps
module irq_status_agg_tb;

  localparam int NB = 4;
  localparam int IW = 2;
  localparam int KIND_RD = 0, KIND_IRQ = 1, KIND_REARM = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] bus_rst = '0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_bus = '0;
  logic [1:0]    wr_sel = '0;
  logic [31:0]   wr_data = '0;
  logic [IW-1:0] rd_bus = '0;
  logic [1:0]    rd_sel = 2'd3;
  logic [31:0]   rd_data;
  logic [NB-1:0] ev_tx_ack = '0, ev_tx_nak = '0, ev_rx_done = '0, ev_arb_loss = '0;
  logic [NB-1:0] ev_stop_ok = '0, ev_stop_bad = '0, ev_scl_timeout = '0;
  logic [NB-1:0] rx_pending = '0;
  logic [NB-1:0] irq;
  logic [NB-1:0] rx_rearm;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       msg_q[$];

  always #2.5 clk = ~clk;

  irq_status_agg #(.NUM_BUS(NB), .DATA_W(32)) u_dut (
    .clk(clk), .rst(rst), .bus_rst(bus_rst),
    .wr_en(wr_en), .wr_bus(wr_bus), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_bus(rd_bus), .rd_sel(rd_sel), .rd_data(rd_data),
    .ev_tx_ack(ev_tx_ack), .ev_tx_nak(ev_tx_nak), .ev_rx_done(ev_rx_done),
    .ev_arb_loss(ev_arb_loss), .ev_stop_ok(ev_stop_ok), .ev_stop_bad(ev_stop_bad),
    .ev_scl_timeout(ev_scl_timeout), .rx_pending(rx_pending),
    .irq(irq), .rx_rearm(rx_rearm)
  );

  // Monitor: compares each queued expectation at the falling edge.
  always @(negedge clk) begin
    while (kind_q.size() > 0) begin
      int          k;
      logic [31:0] e;
      logic [31:0] a;
      string       m;
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      m = msg_q.pop_front();
      if (k == KIND_RD)       a = rd_data;
      else if (k == KIND_IRQ) a = {{(32-NB){1'b0}}, irq};
      else                    a = {{(32-NB){1'b0}}, rx_rearm};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", m, a, e);
      end
    end
  end

  task automatic push(input int k, input logic [31:0] e, input string m);
    kind_q.push_back(k);
    exp_q.push_back(e);
    msg_q.push_back(m);
  endtask

  task automatic set_ev(input int b, input logic [6:0] bits);
    ev_tx_ack[b]      = bits[0];
    ev_tx_nak[b]      = bits[1];
    ev_rx_done[b]     = bits[2];
    ev_arb_loss[b]    = bits[3];
    ev_stop_ok[b]     = bits[4];
    ev_stop_bad[b]    = bits[5];
    ev_scl_timeout[b] = bits[6];
  endtask

  task automatic clr_ev();
    ev_tx_ack = '0; ev_tx_nak = '0; ev_rx_done = '0; ev_arb_loss = '0;
    ev_stop_ok = '0; ev_stop_bad = '0; ev_scl_timeout = '0;
  endtask

  task automatic wr(input int b, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_bus = IW'(b); wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ev(input int b, input logic [6:0] bits);
    @(negedge clk);
    set_ev(b, bits);
    @(negedge clk);
    clr_ev();
  endtask

  task automatic wr_ev(input int b, input logic [31:0] d, input logic [6:0] bits);
    @(negedge clk);
    wr_en = 1'b1; wr_bus = IW'(b); wr_sel = 2'd1; wr_data = d;
    set_ev(b, bits);
    @(negedge clk);
    wr_en = 1'b0;
    clr_ev();
  endtask

  task automatic wr_rearm(input int b, input logic [31:0] d, input logic [31:0] e, input string m);
    @(negedge clk);
    wr_en = 1'b1; wr_bus = IW'(b); wr_sel = 2'd1; wr_data = d;
    @(posedge clk); #1 push(KIND_REARM, e, m);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk); #1 push(KIND_REARM, 32'h0, {m, " then low"});
  endtask

  task automatic chk_rd(input int b, input logic [1:0] s, input logic [31:0] e, input string m);
    @(negedge clk);
    rd_bus = IW'(b); rd_sel = s;
    @(posedge clk); #1 push(KIND_RD, e, m);
  endtask

  task automatic chk_irq(input logic [31:0] e, input string m);
    @(posedge clk); #1 push(KIND_IRQ, e, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(32'h0, "R1 irq after reset");
    chk_rd(0, 2'd0, 32'h0, "R1 enable after reset");
    chk_rd(0, 2'd1, 32'h0, "R1 status after reset");
    chk_rd(0, 2'd2, 32'h0, "R1 map after reset");
    // R2 enable width
    wr(0, 2'd0, 32'hFFFF_FFFF);
    chk_rd(0, 2'd0, 32'h7FFF, "R2 enable upper bits dropped");
    wr(1, 2'd0, 32'h15);
    chk_rd(1, 2'd0, 32'h15, "R2 enable load");
    // R3 masking
    ev(1, 7'b0000010);
    chk_rd(1, 2'd1, 32'h0, "R3 disabled nak leaves no status");
    chk_irq(32'h0, "R3 disabled nak no irq");
    ev(1, 7'b0000001);
    chk_rd(1, 2'd1, 32'h1, "R3 ack sets bit0");
    chk_irq(32'h2, "R4 irq bus1 raised");
    chk_rd(0, 2'd2, 32'h2, "R4 map bus1 set");
    // R5 / R6 clears
    ev(1, 7'b0010000);
    chk_rd(1, 2'd1, 32'h11, "R3 stop sets bit4");
    wr(1, 2'd1, 32'hFFFF_0001);
    chk_rd(1, 2'd1, 32'h10, "R5 partial clear");
    chk_irq(32'h2, "R6 line kept after partial clear");
    wr(1, 2'd1, 32'h10);
    chk_rd(1, 2'd1, 32'h0, "R5 full clear");
    chk_irq(32'h0, "R6 line dropped");
    chk_rd(1, 2'd2, 32'h0, "R6 map dropped");
    // R10 late mask change
    ev(1, 7'b0000100);
    chk_irq(32'h2, "R4 rx done raise");
    wr(1, 2'd0, 32'h0);
    chk_rd(1, 2'd1, 32'h4, "R10 status kept after disable");
    chk_irq(32'h2, "R10 line kept after disable");
    ev(1, 7'b0000001);
    chk_rd(1, 2'd1, 32'h0, "R10 raise prunes to enable");
    chk_irq(32'h2, "R10 line kept on zero raise");
    wr(1, 2'd1, 32'h0);
    chk_irq(32'h0, "R6 write leaving zero drops line");
    // R7 re-arm
    wr(2, 2'd0, 32'h7FFF);
    ev(2, 7'b0000100);
    chk_irq(32'h4, "R4 bus2 rx done");
    @(negedge clk); rx_pending = 4'b0100;
    wr_rearm(2, 32'h4, 32'h4, "R7 rearm with pending");
    chk_rd(2, 2'd1, 32'h0, "R7 rx done cleared");
    wr_rearm(2, 32'h4, 32'h0, "R7 no rearm when rx done clear");
    @(negedge clk); rx_pending = '0;
    ev(2, 7'b0000100);
    wr_rearm(2, 32'h4, 32'h0, "R7 no rearm without pending");
    chk_irq(32'h0, "R6 bus2 cleared");
    // R11 ordering
    ev(2, 7'b0000001);
    wr_ev(2, 32'h1, 7'b0000001);
    chk_rd(2, 2'd1, 32'h1, "R11 event survives same-cycle clear");
    wr_ev(2, 32'h1, 7'b0010000);
    chk_rd(2, 2'd1, 32'h10, "R11 clear then set");
    chk_irq(32'h4, "R11 line high after combined cycle");
    // R9 map writes ignored
    wr(2, 2'd2, 32'h0);
    wr(0, 2'd2, 32'hFFFF_FFFF);
    wr(0, 2'd3, 32'hFFFF_FFFF);
    chk_rd(0, 2'd2, 32'h4, "R9 map unchanged");
    chk_irq(32'h4, "R9 irq unchanged");
    chk_rd(0, 2'd0, 32'h7FFF, "R9 enable unchanged");
    // R8 per-bus reset
    wr(3, 2'd0, 32'h7FFF);
    ev(3, 7'b0100000);
    chk_rd(3, 2'd1, 32'h20, "R3 abnormal stop bit5");
    chk_irq(32'hC, "R4 bus3 raised");
    @(negedge clk); bus_rst = 4'b1000;
    @(negedge clk); bus_rst = '0;
    chk_rd(3, 2'd0, 32'h0, "R8 enable cleared");
    chk_rd(3, 2'd1, 32'h0, "R8 status cleared");
    chk_irq(32'h4, "R8 only bus3 line dropped");
    chk_rd(2, 2'd1, 32'h10, "R8 bus2 untouched");
    // R1 controller reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_irq(32'h0, "R1 irq after second reset");
    chk_rd(2, 2'd1, 32'h0, "R1 status after second reset");
    chk_rd(0, 2'd2, 32'h0, "R1 map after second reset");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule